// File: doc/BRIEF.md
# Per-CPU Interval Tick Skip Counter

This block sits between a periodic interval timer and a group of CPUs. Each CPU owns a counter that swallows a programmed number of timer ticks before it starts passing them on. The shared timer line is edge-detected inside the block. Every rising level is one tick, and every tick decrements all counters at once.

A counter that decrements below zero raises a sticky overflow flag through the borrow. From then on, each tick that leaves the flag set sends a one-cycle timer-interrupt set pulse to that CPU's interrupt status logic. The count keeps decrementing after overflow, so software can read the register back and learn how many ticks were skipped. Writing a counter arms it again: the write loads a new count and clears the flag.

Top module: `tick_skip_ctrl`

## Requirements
- R1: After reset every counter reads zero with its overflow flag clear, and no set pulse is active.
- R2: A write to a counter's address loads bits 23:0 of the write data into the count and clears the overflow flag. Bits 31:24 of the write data are ignored. A read returns the count in bits 23:0, the overflow flag in bit 24, and zero in bits 31:25.
- R3: Each rising edge of the timer line decrements every counter's 24-bit count by one, modulo 2^24.
- R4: A timer line that stays high, stays low or falls changes no counter. A level held high for many cycles counts as a single tick.
- R5: A tick on a counter whose 25-bit value {overflow, count} is zero sets the overflow flag and leaves the count at 0xFFFFFF.
- R6: Once set, the overflow flag stays set through any number of further ticks until the counter is written. The count keeps decrementing while the flag is set.
- R7: One cycle after a tick, a CPU's set pulse is high for exactly one cycle if its overflow flag is set after that tick. A CPU whose flag is clear after the tick gets no pulse, and no pulse appears without a tick.
- R8: When a write and a tick fall in the same cycle, the written counter takes the written value and ignores that tick, and it produces no pulse. All other counters take the tick as usual.
- R9: The counters for CPU0, CPU1, CPU2 and CPU3 sit at byte offsets 0x380, 0x3C0, 0x700 and 0x740. A write to any other offset changes no counter. A read of any other offset returns zero with the hit output low, and a read of a counter offset drives the hit output high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_lvl_i | input | 1 | Level of the shared interval timer interrupt line |
| reg_wr_i | input | 1 | Write strobe for the register at reg_addr_i |
| reg_addr_i | input | 12 | Byte offset for both reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| reg_hit_o | output | 1 | High when reg_addr_i selects a counter |
| tmr_set_o | output | 4 | Per-CPU timer-interrupt set pulse |

## Verification
A software write to a counter and a rising edge of the timer line can land in the same clock cycle. The bench provokes this by raising the timer line and issuing a write to one CPU in the same cycle. It then checks that the written CPU holds exactly the written value and gives no pulse, while the other three CPUs decrement and pulse according to their own overflow state. Underflow is also driven from zero in the same way, with every counter read back and the pulse vector compared against an arithmetic model on each tick.

// File: rtl/tick_skip_pkg.sv
package tick_skip_pkg;

    localparam int REG_AW = 12;

    // Byte offset of the counter owned by CPU idx: two pairs in separate blocks
    function automatic logic [REG_AW-1:0] cpu_offset(input int idx);
        if (idx < 2)
            return REG_AW'(12'h380 + idx * 64);
        else
            return REG_AW'(12'h700 + (idx - 2) * 64);
    endfunction

endpackage

// File: rtl/tick_edge_det.sv
module tick_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic tick_o
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        tick_o    = lvl_i & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Two rising edges cannot be back to back
    p_single_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/tick_addr_dec.sv
module tick_addr_dec
    import tick_skip_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [REG_AW-1:0]  addr_i,
    input  logic               wr_i,
    output logic [NUM_CPU-1:0] rd_sel_o,
    output logic [NUM_CPU-1:0] wr_sel_o,
    output logic               hit_o
);

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_sel
        assign rd_sel_o[g] = (addr_i == cpu_offset(g));
        assign wr_sel_o[g] = rd_sel_o[g] & wr_i;
    end

    assign hit_o = |rd_sel_o;

endmodule

// File: rtl/skip_counter.sv
module skip_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W:0]   val_o,
    output logic             pulse_o
);

    localparam int VAL_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W:0] val;
        logic           pulse;
    } cnt_state_t;

    cnt_state_t     st_d, st_q;
    logic [CNT_W:0] dec;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        dec        = st_q.val - VAL_W'(1);
        if (wr_i) begin
            st_d.val = {1'b0, wdata_i};
        end else if (tick_i) begin
            st_d.val   = dec | {st_q.val[CNT_W], {CNT_W{1'b0}}};
            st_d.pulse = st_d.val[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o   = st_q.val;
    assign pulse_o = st_q.pulse;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (val_o == {1'b0, $past(wdata_i)}));

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_i) |=> (val_o[CNT_W-1:0] == $past(val_o[CNT_W-1:0]) - CNT_W'(1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_i) |=> $stable(val_o));

    p_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_i && val_o == '0) |=> (val_o[CNT_W] && (&val_o[CNT_W-1:0])));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (val_o[CNT_W] && !wr_i) |=> val_o[CNT_W]);

    p_pulse_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> val_o[CNT_W]);

    p_pulse_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !pulse_o);

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && wr_i) |=> !pulse_o);

endmodule

// File: rtl/tick_skip_ctrl.sv
module tick_skip_ctrl
    import tick_skip_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CNT_W   = 24,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               timer_lvl_i,
    input  logic               reg_wr_i,
    input  logic [11:0]        reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               reg_hit_o,
    output logic [NUM_CPU-1:0] tmr_set_o
);

    localparam int VAL_W = CNT_W + 1;

    logic               tick;
    logic [NUM_CPU-1:0] rd_sel;
    logic [NUM_CPU-1:0] wr_sel;
    logic [VAL_W-1:0]   cnt_val [NUM_CPU];
    logic [DATA_W-1:0]  rd_mux;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:CNT_W];

    tick_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (timer_lvl_i),
        .tick_o (tick)
    );

    tick_addr_dec #(
        .NUM_CPU (NUM_CPU)
    ) u_dec (
        .addr_i   (reg_addr_i),
        .wr_i     (reg_wr_i),
        .rd_sel_o (rd_sel),
        .wr_sel_o (wr_sel),
        .hit_o    (reg_hit_o)
    );

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        skip_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .wr_i    (wr_sel[g]),
            .wdata_i (reg_wdata_i[CNT_W-1:0]),
            .val_o   (cnt_val[g]),
            .pulse_o (tmr_set_o[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (rd_sel[i]) rd_mux = rd_mux | DATA_W'(cnt_val[i]);
        end
    end

    assign reg_rdata_o = rd_mux;

    // At most one counter is addressed
    p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_hit_o |-> (reg_rdata_o == '0));

endmodule

// File: tb/tick_skip_ctrl_tb.sv
`timescale 1ns/100ps
module tick_skip_ctrl_tb;

    localparam logic [11:0] OFFS [4] = '{12'h380, 12'h3C0, 12'h700, 12'h740};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        timer_lvl_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [11:0] reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        reg_hit_o;
    logic [3:0]  tmr_set_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic [24:0] model [4];

    tick_skip_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .timer_lvl_i (timer_lvl_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .reg_hit_o   (reg_hit_o),
        .tmr_set_o   (tmr_set_o)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [24:0] tick_of(input logic [24:0] v);
        return ((v - 25'd1) & 25'h1FFFFFF) | (v & 25'h1000000);
    endfunction

    // Read every counter back, called just after a falling edge
    task automatic check_all(input string req);
        for (int c = 0; c < 4; c++) begin
            reg_addr_i = OFFS[c];
            #0.3;
            check(req, reg_rdata_o, {7'd0, model[c]});
            check({req, " hit"}, {31'd0, reg_hit_o}, 32'd1);
        end
    endtask

    task automatic write_cpu(input int c, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = OFFS[c]; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
        model[c] = {1'b0, d[23:0]};
    endtask

    // One rising timer edge, optional write collision on cpu wc (-1 = none)
    task automatic do_tick(input int wc, input logic [31:0] d, input string req);
        logic [3:0] exp_p;
        @(negedge clk);
        timer_lvl_i = 1'b1;
        if (wc >= 0) begin
            reg_wr_i = 1'b1; reg_addr_i = OFFS[wc]; reg_wdata_i = d;
        end
        @(negedge clk);
        timer_lvl_i = 1'b0; reg_wr_i = 1'b0;
        exp_p = '0;
        for (int c = 0; c < 4; c++) begin
            if (c == wc) model[c] = {1'b0, d[23:0]};
            else begin
                model[c] = tick_of(model[c]);
                exp_p[c] = model[c][24];
            end
        end
        check({req, " pulse"}, {28'd0, tmr_set_o}, {28'd0, exp_p});
        check_all(req);
        @(negedge clk);
        check({req, " pulse width"}, {28'd0, tmr_set_o}, 32'd0);
    endtask

    initial begin
        for (int c = 0; c < 4; c++) model[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pulses", {28'd0, tmr_set_o}, 32'd0);
        check_all("R1 reset value");

        // R2: load, upper data bits ignored
        write_cpu(2, 32'hFFAB_CDEF);
        check_all("R2 load");
        write_cpu(2, 32'h0000_0000);

        // R3 R5 R6 R7: sweep small start values on each CPU
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 4; s++) begin
                write_cpu(c, 32'(s * 3));
                check_all("R2 readback");
                for (int t = 0; t < s * 3 + 3; t++) do_tick(-1, '0, "R3 R5 R6 R7 tick");
            end
        end

        // R2: write clears a set overflow flag
        write_cpu(0, 32'h0000_0002);
        check_all("R2 clears overflow");

        // R4: long high level counts once, fall is ignored
        @(negedge clk);
        timer_lvl_i = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 4; c++) model[c] = tick_of(model[c]);
        repeat (6) @(negedge clk);
        check_all("R4 held high");
        check("R4 no pulse while held", {31'd0, tmr_set_o[0]}, 32'd0);
        timer_lvl_i = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R4 falling edge");
        check("R4 no pulse on fall", {28'd0, tmr_set_o}, 32'd0);

        // R8: write and tick in the same cycle
        write_cpu(3, 32'h0000_0000);
        do_tick(3, 32'h0000_0007, "R8 collision cpu3");
        do_tick(1, 32'h0000_0000, "R8 collision cpu1");
        do_tick(-1, '0, "R8 after collision");

        // R9: writes to unmapped offsets change nothing, reads miss
        foreach (OFFS[k]) begin
            @(negedge clk);
            reg_wr_i = 1'b1; reg_addr_i = OFFS[k] + 12'h004; reg_wdata_i = 32'h0012_3456;
            @(negedge clk);
            reg_wr_i = 1'b0;
            #0.3;
            check("R9 miss read", reg_rdata_o, 32'd0);
            check("R9 miss hit", {31'd0, reg_hit_o}, 32'd0);
        end
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = 12'h000; reg_wdata_i = 32'h0000_0055;
        @(negedge clk);
        reg_wr_i = 1'b0;
        check_all("R9 unmapped writes ignored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        end
    end

endmodule